// File: doc/BRIEF.md
# Event Priority Resolver for Instruction Boundaries

This block sits beside an instruction sequencer. Each time the sequencer reaches an instruction boundary it pulses a strobe. The resolver then looks at every condition that could stop the next instruction. These are debug traps left by the instruction that just finished, breakpoint hits on the next one, the two external interrupt lines, faults on fetch and decode, the coprocessor state and faults on each operand memory reference. From all of these it reports the single event that must be serviced first.

The result is registered. One cycle after the strobe it gives a one-cycle valid pulse together with an 8-bit vector number and an event class. The vector and class stay on the outputs until the next strobe. Only one event is reported per strobe. A faulting instruction is expected to be retried after its handler runs, and the same evaluation then repeats on the next strobe. The non-maskable line is edge-sensitive. Its edge is remembered in a pending bit, and further non-maskable events are held off until the handler signals its return.

Top module: `excp_prio_resolver`

## Requirements
- R1: `evt_valid_o` is high for exactly the one cycle after a clock edge that sampled `boundary_i` high with an event pending. At a strobe with nothing pending, valid stays low and vector and class become 0. Between strobes, vector and class hold their values.
- R2: The class encoding is 0 none, 1 trap, 2 fault, 3 external interrupt.
- R3: A single-step or data-breakpoint trap from the completed instruction (`step_trap_i`) has the highest priority and reports vector 1, class trap.
- R4: An instruction breakpoint on the next instruction (`ibrk_hit_i`) reports vector 1, class fault. It ranks below R3 and above both external interrupts.
- R5: A pending non-maskable event beats a maskable request at the same strobe and reports vector 2, class interrupt. Both external interrupts rank above every fetch, decode, coprocessor and operand fault.
- R6: A maskable request (`intr_req_i`) is considered only while `int_enable_i` is 1. Its vector is `intr_vector_i` as sampled at the winning strobe.
- R7: A rising edge of `nmi_i` sets a pending bit one clock later. Holding the line high does not set it again. The bit clears when the non-maskable event is reported. After that, a new pending bit is held back, and is not dropped, until `nmi_return_i` pulses.
- R8: A segment fault on the fetch of the next instruction reports vector 11 when `fetch_seg_kind_i` is 0 and vector 13 when it is 1. It ranks above a page fault on that fetch, which reports vector 14.
- R9: Decode faults rank below fetch faults, in this order: illegal opcode (vector 6), then a protected-only opcode while `real_or_v86_i` is 1 (vector 6), then an instruction length greater than MAX_ILEN (default 15) (vector 13), then a privilege violation (vector 13). A length equal to MAX_ILEN does not fault.
- R10: Coprocessor checks rank below decode faults, in this order: a WAIT opcode with both TS and MP set gives vector 7. An escape opcode with EM or TS set gives vector 7. A WAIT or escape opcode with the error input high gives vector 16. MP alone, EM on a WAIT opcode, or the error input with no such opcode raise nothing.
- R11: Operand faults rank lowest. References are taken in ascending index. For each reference the segment fault comes before its page fault (vector 14). The segment fault's 2-bit code maps 0 to vector 11, 1 to vector 12, and 2 or 3 to vector 13.
- R12: Each strobe reports at most one event. A later strobe with unchanged conditions reports the same event again.
- R13: A synchronous active-low reset clears the outputs, the pending bit and the hold-off bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boundary_i | input | 1 | Instruction boundary strobe |
| step_trap_i | input | 1 | Single-step or data-breakpoint trap pending |
| ibrk_hit_i | input | 1 | Execution breakpoint on next instruction |
| nmi_i | input | 1 | Non-maskable interrupt line (edge-sensitive) |
| nmi_return_i | input | 1 | Pulse marking end of non-maskable handler |
| intr_req_i | input | 1 | Maskable interrupt request (level) |
| int_enable_i | input | 1 | Maskable interrupt enable flag |
| intr_vector_i | input | VEC_W | Vector supplied with the maskable request |
| fetch_seg_flt_i | input | 1 | Segment fault on next-instruction fetch |
| fetch_seg_kind_i | input | 1 | 0: vector 11, 1: vector 13 for the fetch segment fault |
| fetch_page_flt_i | input | 1 | Page fault on next-instruction fetch |
| illegal_op_i | input | 1 | Undefined opcode decoded |
| prot_only_op_i | input | 1 | Opcode valid only in protected mode |
| real_or_v86_i | input | 1 | Processor is in real or virtual-8086 mode |
| insn_len_i | input | ILEN_W | Decoded instruction length in bytes |
| priv_viol_i | input | 1 | Privilege check on the opcode failed |
| op_wait_i | input | 1 | Next opcode is WAIT |
| op_esc_i | input | 1 | Next opcode is a coprocessor escape |
| cp_em_i | input | 1 | Coprocessor emulate flag |
| cp_mp_i | input | 1 | Coprocessor monitor flag |
| cp_ts_i | input | 1 | Task-switched flag |
| cp_err_i | input | 1 | Coprocessor error input |
| mref_seg_flt_i | input | NUM_MREF | Segment fault per operand reference |
| mref_seg_code_i | input | 2*NUM_MREF | 2-bit segment fault code per reference |
| mref_page_flt_i | input | NUM_MREF | Page fault per operand reference |
| evt_valid_o | output | 1 | One-cycle event pulse |
| evt_vector_o | output | VEC_W | Vector of the selected event |
| evt_class_o | output | 2 | Class of the selected event |

## Verification
The bench builds the resolver with NUM_MREF set to 3, one more than the default. This brings a third operand reference into reach, so the ordering from one reference to the next, and the pairing of each segment fault with its own page fault, can be seen past the first pair. ILEN_W stays at 5 and MAX_ILEN at 15. A length of 16 then faults and a length of exactly 15 does not, which places both sides of the length limit on the bench's inputs.

// File: rtl/excp_pkg.sv
// Package: shared encodings for the boundary event resolver.
// Assumes 8-bit vectors; class codes are fixed by the requirements.
package excp_pkg;

    typedef enum logic [1:0] {
        CLS_NONE  = 2'd0,
        CLS_TRAP  = 2'd1,
        CLS_FAULT = 2'd2,
        CLS_INTR  = 2'd3
    } evt_class_e;

    localparam logic [7:0] VEC_DBG    = 8'd1;
    localparam logic [7:0] VEC_NMI    = 8'd2;
    localparam logic [7:0] VEC_BADOP  = 8'd6;
    localparam logic [7:0] VEC_NOCOP  = 8'd7;
    localparam logic [7:0] VEC_SEGABS = 8'd11;
    localparam logic [7:0] VEC_STACK  = 8'd12;
    localparam logic [7:0] VEC_PROT   = 8'd13;
    localparam logic [7:0] VEC_PAGE   = 8'd14;
    localparam logic [7:0] VEC_COPERR = 8'd16;

    // Fixed candidate slots, highest priority first
    localparam int SLOT_STEP    = 0;
    localparam int SLOT_IBRK    = 1;
    localparam int SLOT_NMI     = 2;
    localparam int SLOT_INTR    = 3;
    localparam int SLOT_FSEG    = 4;
    localparam int SLOT_FPAGE   = 5;
    localparam int SLOT_ILL     = 6;
    localparam int SLOT_PROT    = 7;
    localparam int SLOT_LONG    = 8;
    localparam int SLOT_PRIV    = 9;
    localparam int SLOT_WAIT    = 10;
    localparam int SLOT_ESC     = 11;
    localparam int SLOT_CPERR   = 12;
    localparam int FIXED_SLOTS  = 13;

    // Map a 2-bit operand segment fault code to its vector
    function automatic logic [7:0] seg_code_vec(input logic [1:0] code);
        case (code)
            2'd0:    return VEC_SEGABS;
            2'd1:    return VEC_STACK;
            default: return VEC_PROT;
        endcase
    endfunction

endpackage

// File: rtl/nmi_tracker.sv
// Module: nmi_tracker
// Latches rising edges of the non-maskable line into a pending bit and
// holds off a second service until the handler-return pulse arrives.
// Assumes nmi_i is already synchronous to clk. An edge sets the bit one
// clock later; a take in the same cycle as a fresh edge keeps the bit set.
module nmi_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_i,
    input  logic take_i,
    input  logic ret_i,
    output logic req_o
);

    logic nmi_q;
    logic pend_q;
    logic hold_q;
    logic edge_seen;

    assign edge_seen = nmi_i & ~nmi_q;
    assign req_o     = pend_q & ~hold_q;

    // Track line level, pending bit and hold-off bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_q  <= 1'b0;
            pend_q <= 1'b0;
            hold_q <= 1'b0;
        end else begin
            nmi_q  <= nmi_i;
            pend_q <= (pend_q & ~take_i) | edge_seen;
            if (take_i)
                hold_q <= 1'b1;
            else if (ret_i)
                hold_q <= 1'b0;
        end
    end

    assert_take_only_when_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |-> (pend_q && !hold_q));

    assert_hold_after_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(take_i)) |-> hold_q);

    assert_pend_needs_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(pend_q) && !($past(nmi_i) && !$past(nmi_q))) |-> !pend_q);

endmodule

// File: rtl/cand_builder.sv
// Module: cand_builder
// Turns the raw boundary conditions into a flat, priority-ordered list of
// candidate events, each with its vector and class. Slot 0 is the most
// urgent. Operand references occupy two slots each (segment, then page)
// in ascending reference index after the fixed slots.
module cand_builder
    import excp_pkg::*;
#(
    parameter int NUM_MREF = 2,
    parameter int ILEN_W   = 5,
    parameter int MAX_ILEN = 15,
    parameter int VEC_W    = 8,
    localparam int NCAND   = FIXED_SLOTS + 2 * NUM_MREF
) (
    input  logic                          step_trap_i,
    input  logic                          ibrk_hit_i,
    input  logic                          nmi_req_i,
    input  logic                          intr_req_i,
    input  logic                          int_enable_i,
    input  logic [VEC_W-1:0]              intr_vector_i,
    input  logic                          fetch_seg_flt_i,
    input  logic                          fetch_seg_kind_i,
    input  logic                          fetch_page_flt_i,
    input  logic                          illegal_op_i,
    input  logic                          prot_only_op_i,
    input  logic                          real_or_v86_i,
    input  logic [ILEN_W-1:0]             insn_len_i,
    input  logic                          priv_viol_i,
    input  logic                          op_wait_i,
    input  logic                          op_esc_i,
    input  logic                          cp_em_i,
    input  logic                          cp_mp_i,
    input  logic                          cp_ts_i,
    input  logic                          cp_err_i,
    input  logic [NUM_MREF-1:0]           mref_seg_flt_i,
    input  logic [2*NUM_MREF-1:0]         mref_seg_code_i,
    input  logic [NUM_MREF-1:0]           mref_page_flt_i,
    output logic [NCAND-1:0]              req_o,
    output logic [NCAND-1:0][VEC_W-1:0]   vec_o,
    output logic [NCAND-1:0][1:0]         cls_o
);

    // Fill every candidate slot from the boundary conditions
    always_comb begin
        req_o = '0;
        vec_o = '0;
        cls_o = '0;

        req_o[SLOT_STEP]  = step_trap_i;
        vec_o[SLOT_STEP]  = VEC_W'(VEC_DBG);
        cls_o[SLOT_STEP]  = CLS_TRAP;

        req_o[SLOT_IBRK]  = ibrk_hit_i;
        vec_o[SLOT_IBRK]  = VEC_W'(VEC_DBG);
        cls_o[SLOT_IBRK]  = CLS_FAULT;

        req_o[SLOT_NMI]   = nmi_req_i;
        vec_o[SLOT_NMI]   = VEC_W'(VEC_NMI);
        cls_o[SLOT_NMI]   = CLS_INTR;

        req_o[SLOT_INTR]  = intr_req_i & int_enable_i;
        vec_o[SLOT_INTR]  = intr_vector_i;
        cls_o[SLOT_INTR]  = CLS_INTR;

        req_o[SLOT_FSEG]  = fetch_seg_flt_i;
        vec_o[SLOT_FSEG]  = fetch_seg_kind_i ? VEC_W'(VEC_PROT) : VEC_W'(VEC_SEGABS);
        cls_o[SLOT_FSEG]  = CLS_FAULT;

        req_o[SLOT_FPAGE] = fetch_page_flt_i;
        vec_o[SLOT_FPAGE] = VEC_W'(VEC_PAGE);
        cls_o[SLOT_FPAGE] = CLS_FAULT;

        req_o[SLOT_ILL]   = illegal_op_i;
        vec_o[SLOT_ILL]   = VEC_W'(VEC_BADOP);
        cls_o[SLOT_ILL]   = CLS_FAULT;

        req_o[SLOT_PROT]  = prot_only_op_i & real_or_v86_i;
        vec_o[SLOT_PROT]  = VEC_W'(VEC_BADOP);
        cls_o[SLOT_PROT]  = CLS_FAULT;

        req_o[SLOT_LONG]  = (insn_len_i > ILEN_W'(MAX_ILEN));
        vec_o[SLOT_LONG]  = VEC_W'(VEC_PROT);
        cls_o[SLOT_LONG]  = CLS_FAULT;

        req_o[SLOT_PRIV]  = priv_viol_i;
        vec_o[SLOT_PRIV]  = VEC_W'(VEC_PROT);
        cls_o[SLOT_PRIV]  = CLS_FAULT;

        req_o[SLOT_WAIT]  = op_wait_i & cp_ts_i & cp_mp_i;
        vec_o[SLOT_WAIT]  = VEC_W'(VEC_NOCOP);
        cls_o[SLOT_WAIT]  = CLS_FAULT;

        req_o[SLOT_ESC]   = op_esc_i & (cp_em_i | cp_ts_i);
        vec_o[SLOT_ESC]   = VEC_W'(VEC_NOCOP);
        cls_o[SLOT_ESC]   = CLS_FAULT;

        req_o[SLOT_CPERR] = (op_wait_i | op_esc_i) & cp_err_i;
        vec_o[SLOT_CPERR] = VEC_W'(VEC_COPERR);
        cls_o[SLOT_CPERR] = CLS_FAULT;

        for (int m = 0; m < NUM_MREF; m++) begin
            req_o[FIXED_SLOTS + 2*m]     = mref_seg_flt_i[m];
            vec_o[FIXED_SLOTS + 2*m]     = VEC_W'(seg_code_vec(mref_seg_code_i[2*m +: 2]));
            cls_o[FIXED_SLOTS + 2*m]     = CLS_FAULT;
            req_o[FIXED_SLOTS + 2*m + 1] = mref_page_flt_i[m];
            vec_o[FIXED_SLOTS + 2*m + 1] = VEC_W'(VEC_PAGE);
            cls_o[FIXED_SLOTS + 2*m + 1] = CLS_FAULT;
        end
    end

endmodule

// File: rtl/prio_pick.sv
// Module: prio_pick
// Fixed-priority selector: grants the lowest-index active request and
// muxes out its vector and class with a one-hot AND-OR tree.
// Assumes slot 0 is the highest priority. Purely combinational; clk and
// rst_n feed only the checks.
module prio_pick #(
    parameter int N     = 17,
    parameter int VEC_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N-1:0]           req_i,
    input  logic [N-1:0][VEC_W-1:0] vec_i,
    input  logic [N-1:0][1:0]      cls_i,
    output logic [N-1:0]           gnt_o,
    output logic                   hit_o,
    output logic [VEC_W-1:0]       vec_o,
    output logic [1:0]             cls_o
);

    // One grant line per slot: active and no higher slot active
    for (genvar g = 0; g < N; g++) begin : g_grant
        if (g == 0) begin : g_top
            assign gnt_o[g] = req_i[g];
        end else begin : g_rest
            assign gnt_o[g] = req_i[g] & ~(|req_i[g-1:0]);
        end
    end

    // AND-OR mux of the granted slot's payload
    always_comb begin
        hit_o = 1'b0;
        vec_o = '0;
        cls_o = '0;
        for (int i = 0; i < N; i++) begin
            hit_o = hit_o | gnt_o[i];
            vec_o = vec_o | (vec_i[i] & {VEC_W{gnt_o[i]}});
            cls_o = cls_o | (cls_i[i] & {2{gnt_o[i]}});
        end
    end

    assert_single_grant_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));

    assert_request_granted_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_i) |-> hit_o);

endmodule

// File: rtl/excp_prio_resolver.sv
// Module: excp_prio_resolver (top)
// At each boundary strobe, selects the single most urgent pending event and
// registers its vector and class; valid pulses for one cycle. Assumes the
// condition inputs are stable in the strobe cycle and the sequencer retries
// a faulting instruction with a fresh strobe.
module excp_prio_resolver
    import excp_pkg::*;
#(
    parameter int NUM_MREF = 2,
    parameter int ILEN_W   = 5,
    parameter int MAX_ILEN = 15,
    parameter int VEC_W    = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  boundary_i,
    input  logic                  step_trap_i,
    input  logic                  ibrk_hit_i,
    input  logic                  nmi_i,
    input  logic                  nmi_return_i,
    input  logic                  intr_req_i,
    input  logic                  int_enable_i,
    input  logic [VEC_W-1:0]      intr_vector_i,
    input  logic                  fetch_seg_flt_i,
    input  logic                  fetch_seg_kind_i,
    input  logic                  fetch_page_flt_i,
    input  logic                  illegal_op_i,
    input  logic                  prot_only_op_i,
    input  logic                  real_or_v86_i,
    input  logic [ILEN_W-1:0]     insn_len_i,
    input  logic                  priv_viol_i,
    input  logic                  op_wait_i,
    input  logic                  op_esc_i,
    input  logic                  cp_em_i,
    input  logic                  cp_mp_i,
    input  logic                  cp_ts_i,
    input  logic                  cp_err_i,
    input  logic [NUM_MREF-1:0]   mref_seg_flt_i,
    input  logic [2*NUM_MREF-1:0] mref_seg_code_i,
    input  logic [NUM_MREF-1:0]   mref_page_flt_i,
    output logic                  evt_valid_o,
    output logic [VEC_W-1:0]      evt_vector_o,
    output logic [1:0]            evt_class_o
);

    localparam int NCAND = FIXED_SLOTS + 2 * NUM_MREF;

    logic                        nmi_req;
    logic                        nmi_take;
    logic [NCAND-1:0]            cand_req;
    logic [NCAND-1:0][VEC_W-1:0] cand_vec;
    logic [NCAND-1:0][1:0]       cand_cls;
    logic [NCAND-1:0]            gnt;
    logic                        pick_hit;
    logic [VEC_W-1:0]            pick_vec;
    logic [1:0]                  pick_cls;

    assign nmi_take = boundary_i & gnt[SLOT_NMI];

    nmi_tracker i_nmi (
        .clk    (clk),
        .rst_n  (rst_n),
        .nmi_i  (nmi_i),
        .take_i (nmi_take),
        .ret_i  (nmi_return_i),
        .req_o  (nmi_req)
    );

    cand_builder #(
        .NUM_MREF (NUM_MREF),
        .ILEN_W   (ILEN_W),
        .MAX_ILEN (MAX_ILEN),
        .VEC_W    (VEC_W)
    ) i_cand (
        .step_trap_i      (step_trap_i),
        .ibrk_hit_i       (ibrk_hit_i),
        .nmi_req_i        (nmi_req),
        .intr_req_i       (intr_req_i),
        .int_enable_i     (int_enable_i),
        .intr_vector_i    (intr_vector_i),
        .fetch_seg_flt_i  (fetch_seg_flt_i),
        .fetch_seg_kind_i (fetch_seg_kind_i),
        .fetch_page_flt_i (fetch_page_flt_i),
        .illegal_op_i     (illegal_op_i),
        .prot_only_op_i   (prot_only_op_i),
        .real_or_v86_i    (real_or_v86_i),
        .insn_len_i       (insn_len_i),
        .priv_viol_i      (priv_viol_i),
        .op_wait_i        (op_wait_i),
        .op_esc_i         (op_esc_i),
        .cp_em_i          (cp_em_i),
        .cp_mp_i          (cp_mp_i),
        .cp_ts_i          (cp_ts_i),
        .cp_err_i         (cp_err_i),
        .mref_seg_flt_i   (mref_seg_flt_i),
        .mref_seg_code_i  (mref_seg_code_i),
        .mref_page_flt_i  (mref_page_flt_i),
        .req_o            (cand_req),
        .vec_o            (cand_vec),
        .cls_o            (cand_cls)
    );

    prio_pick #(
        .N     (NCAND),
        .VEC_W (VEC_W)
    ) i_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (cand_req),
        .vec_i (cand_vec),
        .cls_i (cand_cls),
        .gnt_o (gnt),
        .hit_o (pick_hit),
        .vec_o (pick_vec),
        .cls_o (pick_cls)
    );

    // Register the selected event at each strobe; pulse valid once
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_valid_o  <= 1'b0;
            evt_vector_o <= '0;
            evt_class_o  <= CLS_NONE;
        end else if (boundary_i) begin
            evt_valid_o  <= pick_hit;
            evt_vector_o <= pick_hit ? pick_vec : '0;
            evt_class_o  <= pick_hit ? pick_cls : CLS_NONE;
        end else begin
            evt_valid_o  <= 1'b0;
        end
    end

    assert_valid_follows_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid_o |-> $past(boundary_i));

    assert_hold_between_strobes_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(boundary_i)) |-> ($stable(evt_vector_o) && $stable(evt_class_o)));

    assert_valid_has_class_R2: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid_o |-> (evt_class_o != CLS_NONE));

    assert_trap_is_debug_vector_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid_o && evt_class_o == CLS_TRAP) |-> (evt_vector_o == VEC_W'(VEC_DBG)));

    assert_masked_intr_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(boundary_i) && !$past(int_enable_i) && !$past(nmi_req))
        |-> (evt_class_o != CLS_INTR));

    assert_reset_clears_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!evt_valid_o && evt_vector_o == '0 && evt_class_o == CLS_NONE));

endmodule

// File: tb/test_excp_prio_resolver.sv
`timescale 1ns/1ps
module test_excp_prio_resolver;

    localparam int NMREF = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic boundary_i = 1'b0;
    logic step_trap_i, ibrk_hit_i, nmi_i, nmi_return_i, intr_req_i, int_enable_i;
    logic [7:0] intr_vector_i;
    logic fetch_seg_flt_i, fetch_seg_kind_i, fetch_page_flt_i;
    logic illegal_op_i, prot_only_op_i, real_or_v86_i, priv_viol_i;
    logic [4:0] insn_len_i;
    logic op_wait_i, op_esc_i, cp_em_i, cp_mp_i, cp_ts_i, cp_err_i;
    logic [NMREF-1:0]   mref_seg_flt_i, mref_page_flt_i;
    logic [2*NMREF-1:0] mref_seg_code_i;
    logic evt_valid_o;
    logic [7:0] evt_vector_o;
    logic [1:0] evt_class_o;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    excp_prio_resolver #(.NUM_MREF(NMREF), .ILEN_W(5), .MAX_ILEN(15), .VEC_W(8)) i_excp_prio_resolver (
        .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i),
        .step_trap_i(step_trap_i), .ibrk_hit_i(ibrk_hit_i),
        .nmi_i(nmi_i), .nmi_return_i(nmi_return_i),
        .intr_req_i(intr_req_i), .int_enable_i(int_enable_i), .intr_vector_i(intr_vector_i),
        .fetch_seg_flt_i(fetch_seg_flt_i), .fetch_seg_kind_i(fetch_seg_kind_i),
        .fetch_page_flt_i(fetch_page_flt_i), .illegal_op_i(illegal_op_i),
        .prot_only_op_i(prot_only_op_i), .real_or_v86_i(real_or_v86_i),
        .insn_len_i(insn_len_i), .priv_viol_i(priv_viol_i),
        .op_wait_i(op_wait_i), .op_esc_i(op_esc_i), .cp_em_i(cp_em_i),
        .cp_mp_i(cp_mp_i), .cp_ts_i(cp_ts_i), .cp_err_i(cp_err_i),
        .mref_seg_flt_i(mref_seg_flt_i), .mref_seg_code_i(mref_seg_code_i),
        .mref_page_flt_i(mref_page_flt_i),
        .evt_valid_o(evt_valid_o), .evt_vector_o(evt_vector_o), .evt_class_o(evt_class_o)
    );

    // Stimulus word bits
    localparam logic [31:0] B_STEP  = 32'd1 << 0;
    localparam logic [31:0] B_IBRK  = 32'd1 << 1;
    localparam logic [31:0] B_INTR  = 32'd1 << 2;
    localparam logic [31:0] B_IF    = 32'd1 << 3;
    localparam logic [31:0] B_FSEG  = 32'd1 << 4;
    localparam logic [31:0] B_FSEL  = 32'd1 << 5;
    localparam logic [31:0] B_FPAGE = 32'd1 << 6;
    localparam logic [31:0] B_ILL   = 32'd1 << 7;
    localparam logic [31:0] B_PROT  = 32'd1 << 8;
    localparam logic [31:0] B_RV86  = 32'd1 << 9;
    localparam logic [31:0] B_LONG  = 32'd1 << 10;
    localparam logic [31:0] B_PRIV  = 32'd1 << 11;
    localparam logic [31:0] B_WAIT  = 32'd1 << 12;
    localparam logic [31:0] B_ESC   = 32'd1 << 13;
    localparam logic [31:0] B_EM    = 32'd1 << 14;
    localparam logic [31:0] B_MP    = 32'd1 << 15;
    localparam logic [31:0] B_TS    = 32'd1 << 16;
    localparam logic [31:0] B_ERR   = 32'd1 << 17;
    localparam logic [31:0] B_MSEG0 = 32'd1 << 18;
    localparam logic [31:0] B_MSEG1 = 32'd1 << 19;
    localparam logic [31:0] B_MSEG2 = 32'd1 << 20;
    localparam logic [31:0] B_MC1_1 = 32'd1 << 23;
    localparam logic [31:0] B_MC2_2 = 32'd2 << 25;
    localparam logic [31:0] B_MC2_3 = 32'd3 << 25;
    localparam logic [31:0] B_MPAGE0 = 32'd1 << 27;
    localparam logic [31:0] B_MPAGE2 = 32'd1 << 29;
    localparam logic [31:0] B_NONE  = 32'd0;

    localparam int NVEC = 25;
    // {stimulus, expected vector, expected class}
    localparam logic [41:0] VECTORS [NVEC] = '{
        {B_NONE, 8'd0, 2'd0},
        {B_STEP | B_IBRK | B_INTR | B_IF | B_FSEG, 8'd1, 2'd1},
        {B_IBRK | B_INTR | B_IF | B_FPAGE, 8'd1, 2'd2},
        {B_INTR | B_IF | B_FSEG | B_FPAGE, 8'h40, 2'd3},
        {B_INTR | B_FSEG, 8'd11, 2'd2},
        {B_FSEG | B_FSEL | B_FPAGE, 8'd13, 2'd2},
        {B_FPAGE | B_ILL, 8'd14, 2'd2},
        {B_ILL | B_LONG, 8'd6, 2'd2},
        {B_PROT | B_RV86 | B_PRIV, 8'd6, 2'd2},
        {B_PROT | B_PRIV, 8'd13, 2'd2},
        {B_LONG | B_WAIT | B_TS | B_MP, 8'd13, 2'd2},
        {B_WAIT | B_TS | B_ERR, 8'd16, 2'd2},
        {B_WAIT | B_TS | B_MP | B_ERR, 8'd7, 2'd2},
        {B_ESC | B_EM | B_ERR, 8'd7, 2'd2},
        {B_ESC | B_ERR | B_MSEG0, 8'd16, 2'd2},
        {B_WAIT | B_EM, 8'd0, 2'd0},
        {B_ERR | B_MPAGE0, 8'd14, 2'd2},
        {B_MSEG1 | B_MC1_1 | B_MPAGE0, 8'd14, 2'd2},
        {B_MSEG1 | B_MC1_1, 8'd12, 2'd2},
        {B_MSEG2 | B_MC2_2 | B_MPAGE2, 8'd13, 2'd2},
        {B_MSEG0 | B_MSEG1, 8'd11, 2'd2},
        {B_MPAGE2, 8'd14, 2'd2},
        {B_MSEG2 | B_MC2_3, 8'd13, 2'd2},
        {B_ESC | B_TS, 8'd7, 2'd2},
        {B_WAIT | B_MP, 8'd0, 2'd0}
    };

    function automatic string tag_of(input int i);
        case (i)
            0:               return "R1";
            1:               return "R3";
            2:               return "R4";
            3:               return "R5";
            4:               return "R6";
            5, 6:            return "R8";
            7, 8, 9, 10:     return "R9";
            16, 17, 18, 19, 20, 21, 22: return "R11";
            default:         return "R10";
        endcase
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic apply_stim(input logic [31:0] s);
        step_trap_i      = s[0];
        ibrk_hit_i       = s[1];
        intr_req_i       = s[2];
        int_enable_i     = s[3];
        fetch_seg_flt_i  = s[4];
        fetch_seg_kind_i = s[5];
        fetch_page_flt_i = s[6];
        illegal_op_i     = s[7];
        prot_only_op_i   = s[8];
        real_or_v86_i    = s[9];
        insn_len_i       = s[10] ? 5'd16 : 5'd3;
        priv_viol_i      = s[11];
        op_wait_i        = s[12];
        op_esc_i         = s[13];
        cp_em_i          = s[14];
        cp_mp_i          = s[15];
        cp_ts_i          = s[16];
        cp_err_i         = s[17];
        mref_seg_flt_i   = s[20:18];
        mref_seg_code_i  = s[26:21];
        mref_page_flt_i  = s[29:27];
    endtask

    // Pulse the strobe; returns at the negedge after the capturing edge
    task automatic strobe();
        @(negedge clk) boundary_i = 1'b1;
        @(negedge clk) boundary_i = 1'b0;
    endtask

    task automatic expect_evt(input string req, input logic v, input logic [7:0] vec, input logic [1:0] cls);
        check(req, 16'(evt_valid_o), 16'(v));
        check(req, 16'(evt_vector_o), 16'(vec));
        check(req, 16'(evt_class_o), 16'(cls));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        nmi_i = 1'b0;
        nmi_return_i = 1'b0;
        intr_vector_i = 8'h40;
        apply_stim(B_NONE);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13: reset state
        expect_evt("R13 reset state", 1'b0, 8'd0, 2'd0);

        // Table walk: priority ordering and encodings
        for (int i = 0; i < NVEC; i++) begin
            apply_stim(VECTORS[i][41:10]);
            strobe();
            expect_evt(tag_of(i), VECTORS[i][9:0] != 10'd0 ? 1'b1 : 1'b0,
                       VECTORS[i][9:2], VECTORS[i][1:0]);
            check("R2 class code", 16'(evt_class_o), 16'(VECTORS[i][1:0]));
        end

        // R1: valid lasts one cycle, payload holds
        apply_stim(B_FPAGE);
        strobe();
        expect_evt("R1 pulse", 1'b1, 8'd14, 2'd2);
        apply_stim(B_NONE);
        repeat (3) @(negedge clk);
        expect_evt("R1 hold", 1'b0, 8'd14, 2'd2);
        // R12: retry with unchanged conditions repeats the event
        apply_stim(B_FPAGE);
        strobe();
        expect_evt("R12 retry", 1'b1, 8'd14, 2'd2);
        strobe();
        expect_evt("R12 retry again", 1'b1, 8'd14, 2'd2);
        // R1: empty strobe zeroes payload
        apply_stim(B_NONE);
        strobe();
        expect_evt("R1 empty strobe", 1'b0, 8'd0, 2'd0);
        // R9: length at the limit does not fault
        insn_len_i = 5'd15;
        strobe();
        expect_evt("R9 length 15", 1'b0, 8'd0, 2'd0);
        insn_len_i = 5'd3;

        // R6: vector sampled at the winning strobe
        intr_vector_i = 8'h99;
        apply_stim(B_INTR | B_IF);
        strobe();
        intr_vector_i = 8'h55;
        @(negedge clk);
        expect_evt("R6 vector sampled", 1'b0, 8'h99, 2'd3);
        intr_vector_i = 8'h40;

        // R5/R7: NMI beats INTR
        nmi_i = 1'b1;
        @(negedge clk);
        strobe();
        expect_evt("R5 nmi over intr", 1'b1, 8'd2, 2'd3);
        strobe();
        expect_evt("R7 level no retrigger", 1'b1, 8'h40, 2'd3);
        apply_stim(B_NONE);
        nmi_i = 1'b0;
        @(negedge clk) nmi_i = 1'b1;
        @(negedge clk);
        strobe();
        expect_evt("R7 held off", 1'b0, 8'd0, 2'd0);
        nmi_return_i = 1'b1;
        @(negedge clk) nmi_return_i = 1'b0;
        strobe();
        expect_evt("R7 serviced after return", 1'b1, 8'd2, 2'd3);
        nmi_return_i = 1'b1;
        @(negedge clk) nmi_return_i = 1'b0;
        nmi_i = 1'b0;
        @(negedge clk) nmi_i = 1'b1;
        @(negedge clk);
        apply_stim(B_STEP);
        strobe();
        expect_evt("R3 trap over nmi", 1'b1, 8'd1, 2'd1);
        apply_stim(B_NONE);
        strobe();
        expect_evt("R7 pending kept", 1'b1, 8'd2, 2'd3);

        // R13: reset clears pending and hold-off
        nmi_return_i = 1'b1;
        @(negedge clk) nmi_return_i = 1'b0;
        nmi_i = 1'b0;
        @(negedge clk) nmi_i = 1'b1;
        @(negedge clk) nmi_i = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        strobe();
        expect_evt("R13 pending cleared", 1'b0, 8'd0, 2'd0);
        nmi_i = 1'b1;
        @(negedge clk);
        strobe();
        expect_evt("R13 hold-off cleared", 1'b1, 8'd2, 2'd3);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule